// File: doc/BRIEF.md
# Pseudo-Random Heater Gate Modulator

This block drives the gate of a heater switch with a stream of random-looking bits instead of a fixed-period square wave. A long-run average of the gate bit follows a programmed 16-bit level, so the heater receives the intended mean power. The switching energy spreads into a broad noise floor rather than piling up at the harmonics of one switching frequency.

A 16-bit maximal-length shift register supplies the random value. At each update the current value is compared with the level. The gate goes high when that value is below the level, and the register then steps once. A prescaler spaces the updates `128 - speed` clock cycles apart, with `speed` being a 7-bit setting. Between updates the gate bit holds.

`level_i` and `speed_i` are plain control pins that are sampled at each update, with no handshake. If the register ever holds all zeros, the next update reloads the seed so that it cannot lock up.

Top module: `prob_pulse_mod`

## Requirements
- R1: While `rst` is high, `gate_o` is 0. The random register returns to seed 0xACE1 and the prescaler returns to terminal count, so the first update comes at the first clock edge after `rst` falls.
- R2: At each update, `gate_o` takes the value 1 if the random value before the step is less than `level_i`, and 0 otherwise.
- R3: With `level_i` = 0x0000, `gate_o` stays 0 on every update.
- R4: With `level_i` = 0xFFFF, `gate_o` is 1 on every update except the one where the random value is 0xFFFF, so 65534 of every 65535 updates give a high gate.
- R5: The random value steps right with feedback bit 15 = s[0]^s[2]^s[3]^s[5], which is the polynomial with taps 16, 14, 13 and 11. It visits all 65535 nonzero states once per period. Over one period the number of high updates is `level_i - 1` for any nonzero level.
- R6: Updates occur every `128 - speed_i` clock cycles. Speed 127 gives an update on every clock and speed 0 gives one every 128 clocks.
- R7: A new `speed_i` value is taken only at an update, and it sets the spacing up to the next update.
- R8: Between updates, `gate_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | 16 | Target high-probability level |
| speed_i | input | 7 | Update-rate setting; spacing is 128 - speed clocks |
| gate_o | output | 1 | Registered heater gate bit |

## Verification
The bench builds the block with its default parameters: a 16-bit random register and a 7-bit speed setting. These widths put a full 65535-state period within reach at speed 127 in about 65k cycles. The bench runs two such periods, at levels 0x4000 and 0xFFFF, and checks the exact high counts. The 7-bit speed setting keeps the widest spacing of 128 clocks short enough for the randomized segments to cover many updates at the slowest, fastest and mid-range rates, including speed changes that arrive in the middle of a count.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  localparam int unsigned DEF_RNG_W   = 16;
  localparam int unsigned DEF_SPEED_W = 7;
  // Fibonacci shift-right feedback: bits 0,2,3,5 (taps 16,14,13,11)
  localparam logic [15:0] DEF_TAPS    = 16'h002D;
  localparam logic [15:0] DEF_SEED    = 16'hACE1;
endpackage

// File: rtl/ppm_prescaler.sv
module ppm_prescaler #(
  parameter int unsigned SPEED_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SPEED_W-1:0] speed,
  output logic               tick,
  output logic [SPEED_W-1:0] count
);
  localparam logic [SPEED_W-1:0] TOP = {SPEED_W{1'b1}};

  logic [SPEED_W-1:0] cnt_q;

  assign tick  = (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= TOP - speed;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ppm_rng.sv
module ppm_rng #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  TAPS = 16'h002D,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;
  logic [W-1:0] masked;
  logic         fb;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      assign masked[gi] = state_q[gi] & TAPS[gi];
    end
  endgenerate

  assign fb = ^masked;

  always_comb begin
    if (state_q == '0) begin
      state_nxt = SEED;
    end else begin
      state_nxt = {fb, state_q[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= state_nxt;
    end
  end

  assign value = state_q;
endmodule

// File: rtl/ppm_gate_out.sv
module ppm_gate_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         update,
  input  logic [W-1:0] rnd,
  input  logic [W-1:0] level,
  output logic         gate
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
    end else if (update) begin
      gate_q <= (rnd < level);
    end
  end

  assign gate = gate_q;
endmodule

// File: rtl/prob_pulse_mod.sv
module prob_pulse_mod #(
  parameter int unsigned         RNG_W   = ppm_pkg::DEF_RNG_W,
  parameter int unsigned         SPEED_W = ppm_pkg::DEF_SPEED_W,
  parameter logic [RNG_W-1:0]    TAPS    = ppm_pkg::DEF_TAPS,
  parameter logic [RNG_W-1:0]    SEED    = ppm_pkg::DEF_SEED
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RNG_W-1:0]   level_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               gate_o
);
  logic               tick;
  logic [SPEED_W-1:0] pre_cnt;
  logic [RNG_W-1:0]   rnd;

  ppm_prescaler #(.SPEED_W(SPEED_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .speed (speed_i),
    .tick  (tick),
    .count (pre_cnt)
  );

  ppm_rng #(.W(RNG_W), .TAPS(TAPS), .SEED(SEED)) u_rng (
    .clk   (clk),
    .rst   (rst),
    .step  (tick),
    .value (rnd)
  );

  ppm_gate_out #(.W(RNG_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .update (tick),
    .rnd    (rnd),
    .level  (level_i),
    .gate   (gate_o)
  );
endmodule

// File: rtl/prob_pulse_mod_chk.sv
module prob_pulse_mod_chk #(
  parameter int unsigned RNG_W   = 16,
  parameter int unsigned SPEED_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic [SPEED_W-1:0] pre_cnt,
  input logic [RNG_W-1:0]   rnd,
  input logic [RNG_W-1:0]   level_i,
  input logic [SPEED_W-1:0] speed_i,
  input logic               gate_o
);
  localparam logic [SPEED_W-1:0] TOP = {SPEED_W{1'b1}};

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !gate_o);

  assert_compare_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> gate_o == ($past(rnd) < $past(level_i)));

  assert_level_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && level_i == '0) |=> !gate_o);

  assert_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rnd != '0);

  assert_fastest_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && speed_i == TOP) |=> tick);

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> pre_cnt == TOP - $past(speed_i));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(gate_o));
endmodule

bind prob_pulse_mod prob_pulse_mod_chk #(.RNG_W(RNG_W), .SPEED_W(SPEED_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .pre_cnt (pre_cnt),
  .rnd     (rnd),
  .level_i (level_i),
  .speed_i (speed_i),
  .gate_o  (gate_o)
);

// File: tb/prob_pulse_mod_tb_top.sv
module prob_pulse_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] level = 16'h0;
  logic [6:0]  speed = 7'd0;
  logic        gate;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  prob_pulse_mod dut_i (
    .clk     (clk),
    .rst     (rst),
    .level_i (level),
    .speed_i (speed),
    .gate_o  (gate)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] s);
    logic b;
    b = s[0] ^ s[2] ^ s[3] ^ s[5];
    return {b, s[15:1]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      if (bad < 20) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model, built from the requirements
  int          m_wait = 0;
  logic [15:0] m_rng = 16'hACE1;
  logic        m_gate = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_wait = 0; m_rng = 16'hACE1; m_gate = 1'b0;
    end else if (m_wait == 0) begin
      m_gate = (m_rng < level);
      m_rng  = ref_step(m_rng);
      m_wait = 127 - int'(speed);
    end else begin
      m_wait--;
    end
  end

  // Per-cycle comparison: R2 value, R6/R7 spacing, R8 hold
  always @(negedge clk) begin
    if (!done) check(cur_req, {31'd0, gate}, {31'd0, m_gate});
  end

  initial begin
    while (cycles < 195000 && !done) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<195000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic full_period(input logic [15:0] lv, input string req, input int exp);
    int highs = 0;
    @(negedge clk);
    speed = 7'd127; level = lv;
    @(negedge clk);
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      highs += int'(gate);
    end
    check(req, highs, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1", {31'd0, gate}, 32'd0);
    level = 16'hFFFF; speed = 7'd3;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, gate}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // first update at first edge: 0xACE1 < 0xFFFF
    check("R1", {31'd0, gate}, 32'd1);

    // R6 slowest and fastest rates
    cur_req = "R6";
    speed = 7'd0; level = 16'h8000;
    repeat (600) @(negedge clk);
    speed = 7'd127;
    repeat (300) @(negedge clk);

    // R7: change speed mid-count
    cur_req = "R7";
    speed = 7'd0;
    repeat (50) @(negedge clk);
    speed = 7'd120;
    repeat (200) @(negedge clk);
    speed = 7'd64;
    repeat (37) @(negedge clk);
    speed = 7'd1;
    repeat (400) @(negedge clk);

    // R3: level zero keeps gate low
    cur_req = "R3";
    level = 16'h0000; speed = 7'd100;
    @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        hi += int'(gate);
      end
      check("R3", hi, 0);
    end

    // R2/R8: random levels and speeds
    cur_req = "R2 R8";
    for (int k = 0; k < 40; k++) begin
      level = $urandom();
      if (k % 8 == 0) level = 16'h0001;
      speed = 7'($urandom());
      repeat (100 + ($urandom() % 200)) @(negedge clk);
    end

    // R5 and R4: full periods
    cur_req = "R5";
    full_period(16'h4000, "R5", 16383);
    cur_req = "R4";
    full_period(16'hFFFF, "R4", 65534);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule